// File: doc/BRIEF.md
# Indirect TCAM Command Engine

This block lets a host reach a ternary match table one page at a time through a small register window. Each table entry has three pages of 26 sixteen-bit words. Pages 0 and 1 hold key bytes, packed as a mask byte over a data byte. Page 0 also carries the frame-type mask and the source-port-vector key. Page 2 holds the action fields. The host fills the data registers and then writes a command word with the busy bit set. The engine then copies a page into the data registers, copies the data registers into a page, clears one entry, clears the whole table, or searches for the next valid entry. It clears busy when the work is done.

An entry counts as valid only when both frame-type mask bits (bits 15:14 of register 2) were set the last time its page 0 was loaded. The engine keeps one valid flag per entry for this purpose. Frame matching against the stored entries belongs to a separate block.

Top module: `tcam_cmd_engine`

## Requirements
- R1: After reset, every register address (0 to 31) reads as zero, so busy is clear.
- R2: Registers 1 (extension) and 2 to 27 (data) read back the last value written. Addresses 28 to 31 read as zero and ignore writes.
- R3: Register 0 is laid out as bit 15 busy, bits 14:12 opcode, bits 11:10 page and bits 9:0 entry field, with the low ENTRY_W bits as the index. A write with bit 15 clear only stores bits 14:0 and starts nothing.
- R4: Opcode 5 (read) copies the addressed page of the addressed entry into data registers 2 to 27, with word r going to register 2+r. Busy reads high for exactly one cycle.
- R5: Opcode 3 (load) copies data registers 2 to 27 into the addressed page. Busy reads high for exactly one cycle.
- R6: Opcode 2 zeroes all three pages of one entry and marks it invalid, in one busy cycle. Other entries are left unchanged.
- R7: Opcode 1 clears one entry per clock from index 0 upward. Busy reads high for exactly 2^ENTRY_W cycles, and afterwards every page of every entry reads zero and no entry is valid.
- R8: An entry is valid if and only if register 2 bits 15:14 were both 1 at its most recent page-0 load and no flush has hit it since. A load with either bit clear makes the entry invalid.
- R9: Opcode 4 writes into the entry field the lowest valid index strictly above the given index. When there is none, it writes 0x3FF. Opcode, page and data registers are not changed.
- R10: While busy is high, host writes to any register are ignored.
- R11: Page value 3 and opcodes 0, 6 and 7 finish in one busy cycle and change neither the table nor the data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe for the addressed register |
| reg_addr | input | 5 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |

## Verification
The bench builds the engine with ENTRY_W = 4, a table of 16 entries. At that size every entry and every page can be loaded with a distinct pattern and read back. Flush-all can be timed to its exact 16-cycle busy span, and next-valid searches can be issued from every start index, including the top one and the ones with no valid entry above. Validity is toggled per entry through the frame-type bits, and single-entry flushes are checked against their neighbours. Reserved pages and opcodes, and writes made during a flush-all, are checked for having no effect.

// File: rtl/tcam_eng_pkg.sv
package tcam_eng_pkg;
  localparam int REG_W       = 16;
  localparam int ADDR_W      = 5;
  localparam int DATA_BASE   = 2;
  localparam int DATA_CNT    = 26;
  localparam int ROW_W       = REG_W * DATA_CNT;
  localparam int PAGE_CNT    = 3;
  localparam int IDX_FIELD_W = 10;
  localparam logic [IDX_FIELD_W-1:0] NO_ENTRY = 10'h3FF;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_FLUSH_ALL = 3'd1,
    OP_FLUSH_ONE = 3'd2,
    OP_LOAD      = 3'd3,
    OP_NEXT      = 3'd4,
    OP_READ      = 3'd5
  } op_e;
endpackage

// File: rtl/tcam_page_bank.sv
module tcam_page_bank #(
  parameter int ENTRY_W = 8,
  parameter int ROW_W   = 416
) (
  input  logic               clk,
  input  logic               we,
  input  logic [ENTRY_W-1:0] addr,
  input  logic [ROW_W-1:0]   wdata,
  output logic [ROW_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ENTRY_W;

  logic [ROW_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/tcam_valid_map.sv
module tcam_valid_map #(
  parameter int ENTRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [ENTRY_W-1:0] addr,
  input  logic               val,
  output logic               hit
);
  localparam int DEPTH = 1 << ENTRY_W;

  logic [DEPTH-1:0] valid_q, valid_d;

  always_comb begin
    valid_d = valid_q;
    if (upd) valid_d[addr] = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign hit = valid_q[addr];
endmodule

// File: rtl/tcam_cmd_ctrl.sv
module tcam_cmd_ctrl
  import tcam_eng_pkg::*;
#(
  parameter int ENTRY_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  op_e                    op_i,
  input  logic [1:0]             page_i,
  input  logic [ENTRY_W-1:0]     idx_i,
  input  logic                   valid_i,
  output logic                   busy_o,
  output logic [ENTRY_W-1:0]     ptr_o,
  output logic [1:0]             page_o,
  output logic                   rd_pg_o,
  output logic                   wr_pg_o,
  output logic                   clr_o,
  output logic                   res_we_o,
  output logic [IDX_FIELD_W-1:0] res_o
);
  localparam logic [ENTRY_W-1:0] LAST = '1;

  logic               busy_q, busy_d;
  op_e                op_q, op_d;
  logic [1:0]         page_q, page_d;
  logic [ENTRY_W-1:0] ptr_q, ptr_d;
  logic               none_q, none_d;
  logic               page_ok;

  assign page_ok = (page_q != 2'd3);

  always_comb begin
    busy_d   = busy_q;
    op_d     = op_q;
    page_d   = page_q;
    ptr_d    = ptr_q;
    none_d   = none_q;
    rd_pg_o  = 1'b0;
    wr_pg_o  = 1'b0;
    clr_o    = 1'b0;
    res_we_o = 1'b0;
    res_o    = IDX_FIELD_W'(ptr_q);
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        op_d   = op_i;
        page_d = page_i;
        none_d = 1'b0;
        case (op_i)
          OP_FLUSH_ALL: ptr_d = '0;
          OP_NEXT: begin
            ptr_d  = idx_i + ENTRY_W'(1);
            none_d = (idx_i == LAST);
          end
          default: ptr_d = idx_i;
        endcase
      end
    end else begin
      case (op_q)
        OP_FLUSH_ALL: begin
          clr_o = 1'b1;
          if (ptr_q == LAST) busy_d = 1'b0;
          else               ptr_d  = ptr_q + ENTRY_W'(1);
        end
        OP_FLUSH_ONE: begin
          clr_o  = 1'b1;
          busy_d = 1'b0;
        end
        OP_LOAD: begin
          wr_pg_o = page_ok;
          busy_d  = 1'b0;
        end
        OP_READ: begin
          rd_pg_o = page_ok;
          busy_d  = 1'b0;
        end
        OP_NEXT: begin
          if (none_q) begin
            res_we_o = 1'b1;
            res_o    = NO_ENTRY;
            busy_d   = 1'b0;
          end else if (valid_i) begin
            res_we_o = 1'b1;
            busy_d   = 1'b0;
          end else if (ptr_q == LAST) begin
            res_we_o = 1'b1;
            res_o    = NO_ENTRY;
            busy_d   = 1'b0;
          end else begin
            ptr_d = ptr_q + ENTRY_W'(1);
          end
        end
        default: busy_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      page_q <= '0;
      ptr_q  <= '0;
      none_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      op_q   <= op_d;
      page_q <= page_d;
      ptr_q  <= ptr_d;
      none_q <= none_d;
    end
  end

  assign busy_o = busy_q;
  assign ptr_o  = ptr_q;
  assign page_o = page_q;
endmodule

// File: rtl/tcam_cmd_engine.sv
module tcam_cmd_engine
  import tcam_eng_pkg::*;
#(
  parameter int ENTRY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic               busy;
  logic [ENTRY_W-1:0] ptr;
  logic [1:0]         page;
  logic               rd_pg, wr_pg, clr, res_we;
  logic [IDX_FIELD_W-1:0] res;
  logic               hit;
  logic               host_wr_ok, start;

  logic [14:0]      op_q, op_d;
  logic [REG_W-1:0] ext_q, ext_d;
  logic [REG_W-1:0] data_q [DATA_CNT];
  logic [REG_W-1:0] data_d [DATA_CNT];

  logic [ROW_W-1:0] row_wr, row_sel;
  logic [ROW_W-1:0] pg_rd [PAGE_CNT];

  assign host_wr_ok = reg_wr & ~busy;
  assign start      = host_wr_ok & (reg_addr == '0) & reg_wdata[15];

  tcam_cmd_ctrl #(.ENTRY_W(ENTRY_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .op_i    (op_e'(reg_wdata[14:12])),
    .page_i  (reg_wdata[11:10]),
    .idx_i   (reg_wdata[ENTRY_W-1:0]),
    .valid_i (hit),
    .busy_o  (busy),
    .ptr_o   (ptr),
    .page_o  (page),
    .rd_pg_o (rd_pg),
    .wr_pg_o (wr_pg),
    .clr_o   (clr),
    .res_we_o(res_we),
    .res_o   (res)
  );

  always_comb begin
    for (int r = 0; r < DATA_CNT; r++) row_wr[r*REG_W +: REG_W] = data_q[r];
  end

  for (genvar p = 0; p < PAGE_CNT; p++) begin : g_page
    logic pg_we;
    assign pg_we = clr | (wr_pg & (page == 2'(p)));
    tcam_page_bank #(.ENTRY_W(ENTRY_W), .ROW_W(ROW_W)) bank_i (
      .clk  (clk),
      .we   (pg_we),
      .addr (ptr),
      .wdata(clr ? '0 : row_wr),
      .rdata(pg_rd[p])
    );
  end

  always_comb begin
    row_sel = '0;
    for (int p = 0; p < PAGE_CNT; p++) begin
      if (page == 2'(p)) row_sel = pg_rd[p];
    end
  end

  tcam_valid_map #(.ENTRY_W(ENTRY_W)) valid_i (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (clr | (wr_pg & (page == 2'd0))),
    .addr (ptr),
    .val  (~clr & (&data_q[0][15:14])),
    .hit  (hit)
  );

  always_comb begin
    op_d  = op_q;
    ext_d = ext_q;
    for (int r = 0; r < DATA_CNT; r++) data_d[r] = data_q[r];
    if (host_wr_ok) begin
      if (reg_addr == ADDR_W'(0)) op_d  = reg_wdata[14:0];
      if (reg_addr == ADDR_W'(1)) ext_d = reg_wdata;
      for (int r = 0; r < DATA_CNT; r++) begin
        if (reg_addr == ADDR_W'(DATA_BASE + r)) data_d[r] = reg_wdata;
      end
    end
    if (rd_pg) begin
      for (int r = 0; r < DATA_CNT; r++) data_d[r] = row_sel[r*REG_W +: REG_W];
    end
    if (res_we) op_d[IDX_FIELD_W-1:0] = res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      ext_q <= '0;
      for (int r = 0; r < DATA_CNT; r++) data_q[r] <= '0;
    end else begin
      op_q  <= op_d;
      ext_q <= ext_d;
      for (int r = 0; r < DATA_CNT; r++) data_q[r] <= data_d[r];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(0)) reg_rdata = {busy, op_q};
    if (reg_addr == ADDR_W'(1)) reg_rdata = ext_q;
    for (int r = 0; r < DATA_CNT; r++) begin
      if (reg_addr == ADDR_W'(DATA_BASE + r)) reg_rdata = data_q[r];
    end
  end
endmodule

// File: rtl/tcam_cmd_engine_chk.sv
module tcam_cmd_engine_chk #(
  parameter int ENTRY_W = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        reg_wr,
  input logic [4:0]  reg_addr,
  input logic [14:0] op_field,
  input logic        clr,
  input logic        wr_pg,
  input logic        rd_pg,
  input logic        res_we
);
  localparam int DEPTH = 1 << ENTRY_W;

  logic [15:0] span_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    span_q <= '0;
    else if (busy) span_q <= span_q + 16'd1;
    else           span_q <= '0;
  end

  AST_SHORT_OP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !(op_field[14:12] == 3'd1 || op_field[14:12] == 3'd4) |=> !busy); // R4

  AST_FLUSH_ALL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && op_field[14:12] == 3'd1 |-> $past(span_q) == 16'(DEPTH - 1)); // R7

  AST_FLUSH_ALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> span_q < 16'(DEPTH)); // R7

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_addr == 5'd0 && !res_we |=> $stable(op_field)); // R10

  AST_MEM_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(clr || wr_pg || rd_pg || res_we)); // R10

  AST_NEXT_ABOVE_START: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> op_field[9:0] == 10'h3FF ||
               op_field[ENTRY_W-1:0] > $past(op_field[ENTRY_W-1:0])); // R9
endmodule

bind tcam_cmd_engine tcam_cmd_engine_chk #(.ENTRY_W(ENTRY_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .reg_wr  (reg_wr),
  .reg_addr(reg_addr),
  .op_field(op_q),
  .clr     (clr),
  .wr_pg   (wr_pg),
  .rd_pg   (rd_pg),
  .res_we  (res_we)
);

// File: tb/tcam_cmd_engine_tb_top.sv
module tcam_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EW  = 4;
  localparam int NE  = 1 << EW;
  localparam int NDR = 26;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;

  int checks;
  int fails;

  logic [15:0] mdl [3][NE][NDR];

  tcam_cmd_engine #(.ENTRY_W(EW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = 5'(a);
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    reg_addr = 5'(a);
    #1;
    v = reg_rdata;
  endtask

  task automatic poll(output int cyc);
    logic [15:0] v;
    cyc = 0;
    rd(0, v);
    while (v[15]) begin
      cyc++;
      @(negedge clk);
      rd(0, v);
    end
  endtask

  task automatic cmd(input logic [15:0] w, output int cyc);
    wr(0, w);
    poll(cyc);
  endtask

  function automatic logic [15:0] opw(input int op, input int pg, input int idx);
    return {1'b1, 3'(op), 2'(pg), 10'(idx)};
  endfunction

  function automatic logic [9:0] exp_next(input int i);
    for (int j = i + 1; j < NE; j++) begin
      if (mdl[0][j][0][15:14] == 2'b11) return 10'(j);
    end
    return 10'h3FF;
  endfunction

  task automatic read_cmp(input int e, input int p, input string req);
    int cyc;
    logic [15:0] v;
    for (int r = 0; r < NDR; r++) wr(2 + r, 16'hA5A5);
    cmd(opw(5, p, e), cyc);
    check({req, " R4 read busy"}, 32'(cyc), 32'd1);
    for (int r = 0; r < NDR; r++) begin
      rd(2 + r, v);
      check({req, " R4 read word"}, {8'(e), 8'(p), v}, {8'(e), 8'(p), mdl[p][e][r]});
    end
  endtask

  task automatic next_cmp(input int i, input string req);
    int cyc;
    logic [15:0] v;
    cmd(opw(4, 1, i), cyc);
    rd(0, v);
    check({req, " R9 next result"}, {8'(i), 6'(v[15:10]), v[9:0]},
          {8'(i), 6'b010001, exp_next(i)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired before end of run");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] v;
    checks = 0;
    fails  = 0;
    reg_wr = 1'b0;
    reg_addr = '0;
    reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state over the whole window
    for (int a = 0; a < 32; a++) begin
      rd(a, v);
      check("R1 reset value", {8'(a), 8'h0, v}, {8'(a), 8'h0, 16'h0});
    end

    // R2: register readback and unmapped addresses
    for (int a = 1; a < 32; a++) wr(a, 16'((a * 16'h0F0F) ^ 16'h5A5A));
    for (int a = 1; a < 32; a++) begin
      rd(a, v);
      check("R2 readback", {8'(a), 8'h0, v},
            {8'(a), 8'h0, (a < 28) ? 16'((a * 16'h0F0F) ^ 16'h5A5A) : 16'h0});
    end
    wr(1, 16'h0000);
    rd(1, v);
    check("R2 extension zero", 32'(v), 32'h0);

    // R3: write without busy bit stores and starts nothing
    wr(0, 16'h2ABC);
    rd(0, v);
    check("R3 store only", 32'(v), 32'h2ABC);
    @(negedge clk);
    rd(0, v);
    check("R3 no start", 32'(v), 32'h2ABC);

    // R7: flush all, exact busy span, all zero
    cmd(opw(1, 0, 0), cyc);
    check("R7 flush-all busy cycles", 32'(cyc), 32'(NE));
    for (int e = 0; e < NE; e++)
      for (int p = 0; p < 3; p++)
        for (int r = 0; r < NDR; r++) mdl[p][e][r] = 16'h0;
    for (int e = 0; e < NE; e++)
      for (int p = 0; p < 3; p++) read_cmp(e, p, "R7 cleared");
    next_cmp(0, "R7 none valid");

    // R5 / R8: load every page; even entries valid, odd entries invalid
    for (int e = 0; e < NE; e++) begin
      for (int p = 0; p < 3; p++) begin
        for (int r = 0; r < NDR; r++) begin
          logic [15:0] val;
          val = 16'((e * 613 + p * 97 + r * 29 + 16'h1357) ^ (r << 9));
          if (p == 0 && r == 0) val = (e % 2 == 0) ? (val | 16'hC000) : (val & 16'h7FFF);
          wr(2 + r, val);
          mdl[p][e][r] = val;
        end
        cmd(opw(3, p, e), cyc);
        check("R5 load busy", 32'(cyc), 32'd1);
      end
    end
    for (int e = 0; e < NE; e++)
      for (int p = 0; p < 3; p++) read_cmp(e, p, "R5 loaded");

    // R9: next-valid from every start index
    for (int i = 0; i < NE; i++) next_cmp(i, "R9 sweep");

    // R6: flush one entry, neighbours untouched
    cmd(opw(2, 0, 4), cyc);
    check("R6 flush-one busy", 32'(cyc), 32'd1);
    for (int p = 0; p < 3; p++)
      for (int r = 0; r < NDR; r++) mdl[p][4][r] = 16'h0;
    for (int p = 0; p < 3; p++) read_cmp(4, p, "R6 flushed");
    for (int p = 0; p < 3; p++) read_cmp(3, p, "R6 neighbour");
    for (int p = 0; p < 3; p++) read_cmp(5, p, "R6 neighbour");
    next_cmp(3, "R6 skip flushed");

    // R8: make entry 5 valid, entry 6 invalid via frame-type bits
    read_cmp(5, 0, "R8 prep");
    wr(2, mdl[0][5][0] | 16'hC000);
    mdl[0][5][0] = mdl[0][5][0] | 16'hC000;
    cmd(opw(3, 0, 5), cyc);
    next_cmp(3, "R8 became valid");
    read_cmp(6, 0, "R8 prep");
    wr(2, (mdl[0][6][0] & 16'h3FFF) | 16'h4000);
    mdl[0][6][0] = (mdl[0][6][0] & 16'h3FFF) | 16'h4000;
    cmd(opw(3, 0, 6), cyc);
    next_cmp(5, "R8 one bit not valid");

    // R11: reserved page and opcodes have no effect
    wr(7, 16'h7777);
    cmd(opw(5, 3, 2), cyc);
    check("R11 page3 busy", 32'(cyc), 32'd1);
    rd(7, v);
    check("R11 page3 read no effect", 32'(v), 32'h7777);
    cmd(opw(3, 3, 2), cyc);
    for (int p = 0; p < 3; p++) read_cmp(2, p, "R11 page3 load no effect");
    wr(7, 16'h7777);
    cmd(opw(7, 0, 2), cyc);
    check("R11 opcode7 busy", 32'(cyc), 32'd1);
    cmd(opw(0, 0, 2), cyc);
    check("R11 opcode0 busy", 32'(cyc), 32'd1);
    rd(7, v);
    check("R11 opcode no effect", 32'(v), 32'h7777);

    // R10: writes during a flush-all are ignored
    wr(2, 16'h1234);
    wr(0, opw(1, 2, 9));
    wr(0, opw(5, 0, 3));
    wr(2, 16'hBEEF);
    wr(1, 16'h00FF);
    poll(cyc);
    rd(0, v);
    check("R10 op reg kept", 32'(v), 32'({1'b0, 3'd1, 2'd2, 10'd9}));
    rd(2, v);
    check("R10 data reg kept", 32'(v), 32'h1234);
    rd(1, v);
    check("R10 extension kept", 32'(v), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule